// File: doc/BRIEF.md
# Port Pin-Change Interrupt and Wake-up Unit

This block manages a general-purpose bidirectional port. It holds a direction register, an output latch and a per-pin enable for change detection. It also stores the register bits that control the pad's open-drain and pull behaviour and drives them straight to the pads. Software reaches all of these through a small register bus with a single-cycle write strobe, a read strobe and a combinational read-data path.

Pin inputs pass through a synchronizer before any logic uses them. A read of the port register returns the synchronized pin levels, whatever the directions are. The same read copies those levels into a reference register. From then on, any enabled pin whose level differs from the reference sets a shared sticky change flag. That flag drives a wake-up output, and it also drives the interrupt request when it is unmasked. Pin 0 is also an external edge interrupt input with a selectable active edge.

Register map (3-bit address): 0 port data, 1 direction (1 = input), 2 change enable, 3 open-drain enable, 4 pull enable, 5 interrupt enable (bit 0 edge, bit 1 change, bit 7 global), 6 interrupt flag (bit 0 edge, bit 1 change), 7 control (bit 0: 1 = rising edge, 0 = falling edge).

Top module: `pinwake_top`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), pinOe is 0, the flag register reads 0, and irq and wake are 0.
- R2: A read of address 0 returns the synchronized pin levels for any direction setting. A write to address 0 drives pinOut. A write to address 1 makes pinOe equal to the inverse of the written value from the next cycle.
- R3: A read of address 0 latches the pin levels as the reference. A later mismatch on a pin whose bit in address 2 is 1 sets flag bit 1 within SYNC_STAGES+1 cycles.
- R4: A pin whose change-enable bit is 0 never sets flag bit 1.
- R5: Flag bit 1 stays set until software writes 0 to it. While a mismatch on an enabled pin persists, the hardware set wins over that write, so the bit remains 1.
- R6: With control bit 0 at 1, a rising edge on pin 0 sets flag bit 0 and a falling edge does not. With control bit 0 at 0, the reverse holds.
- R7: irq is 1 exactly when enable bit 7 is 1 and, for at least one source, flag bit k and enable bit k are both 1 (k in {0,1}).
- R8: wake is 1 exactly when flag bit 1 is 1 and at least one change-enable bit is 1, whatever the interrupt enable bits are.
- R9: Addresses 3 and 4 read back the values written and drive odEn and pullEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (read of address 0 latches the reference) |
| busWdata | input | WIDTH | Write data |
| busRdata | output | WIDTH | Read data, combinational from busAddr |
| pinIn | input | WIDTH | Pad input levels |
| pinOut | output | WIDTH | Output latch to pads |
| pinOe | output | WIDTH | Pad output enable, 1 = driving |
| odEn | output | WIDTH | Open-drain enable per pin |
| pullEn | output | WIDTH | Pull enable per pin |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The assertions assume that busWr and busRd are never high in the same cycle and that busAddr is stable while either strobe is high. They also assume that pin changes are slow compared with the synchronizer, so each level is held for several cycles. The bench drives each bus access as a single strobe between falling edges and changes pins only at falling edges. After each pin change it waits at least SYNC_STAGES+2 cycles before it samples. It writes the flag register only when no pin mismatch or pin 0 edge is pending, except in the deliberate R5 case, where the write must be overridden.

// File: rtl/pinwake_pkg.sv
package pinwake_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 3'd0,
    REG_DIR     = 3'd1,
    REG_WAKEEN  = 3'd2,
    REG_ODRAIN  = 3'd3,
    REG_PULL    = 3'd4,
    REG_IRQEN   = 3'd5,
    REG_IRQFLAG = 3'd6,
    REG_CTRL    = 3'd7
  } regSel_e;

  // bit positions inside the enable and flag registers
  localparam int BIT_EXT    = 0;
  localparam int BIT_CHG    = 1;
  localparam int BIT_GLOBAL = 7;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrWake;
    logic wrOdrain;
    logic wrPull;
    logic wrIrqEn;
    logic wrFlag;
    logic wrCtrl;
    logic rdPort;
  } strobes_t;
endpackage

// File: rtl/pinwake_ctrl.sv
module pinwake_ctrl
  import pinwake_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          stb,
  output regSel_e           rdSel
);
  always_comb begin
    stb   = '0;
    rdSel = regSel_e'(busAddr);
    if (busWr) begin
      case (regSel_e'(busAddr))
        REG_DATA:    stb.wrData   = 1'b1;
        REG_DIR:     stb.wrDir    = 1'b1;
        REG_WAKEEN:  stb.wrWake   = 1'b1;
        REG_ODRAIN:  stb.wrOdrain = 1'b1;
        REG_PULL:    stb.wrPull   = 1'b1;
        REG_IRQEN:   stb.wrIrqEn  = 1'b1;
        REG_IRQFLAG: stb.wrFlag   = 1'b1;
        REG_CTRL:    stb.wrCtrl   = 1'b1;
        default:     stb          = '0;
      endcase
    end
    stb.rdPort = busRd && (regSel_e'(busAddr) == REG_DATA);
  end
endmodule

// File: rtl/pinwake_datapath.sv
module pinwake_datapath
  import pinwake_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  regSel_e          rdSel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] odEn,
  output logic [WIDTH-1:0] pullEn,
  output logic             irq,
  output logic             wake,
  output logic [1:0]       flagQ,
  output logic [2:0]       ieQ,
  output logic [WIDTH-1:0] wakeEnQ
);
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] dataQ, dirQ, odQ, pullQ, refQ;
  logic             edgeRiseQ, pin0PrevQ;
  logic             chgHit, extHit;
  logic [1:0]       flagD;

  // input synchronizer, depth chosen by parameter
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[0] <= '0;
        else       syncQ[0] <= pinIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ     <= '0;
      dirQ      <= '1;
      wakeEnQ   <= '0;
      odQ       <= '0;
      pullQ     <= '0;
      ieQ       <= '0;
      edgeRiseQ <= 1'b0;
      refQ      <= '0;
      pin0PrevQ <= 1'b0;
      flagQ     <= '0;
    end else begin
      if (stb.wrData)   dataQ   <= wdata;
      if (stb.wrDir)    dirQ    <= wdata;
      if (stb.wrWake)   wakeEnQ <= wdata;
      if (stb.wrOdrain) odQ     <= wdata;
      if (stb.wrPull)   pullQ   <= wdata;
      if (stb.wrIrqEn)  ieQ     <= {wdata[BIT_GLOBAL], wdata[BIT_CHG], wdata[BIT_EXT]};
      if (stb.wrCtrl)   edgeRiseQ <= wdata[0];
      if (stb.rdPort)   refQ    <= pinSync;
      pin0PrevQ <= pinSync[0];
      flagQ     <= flagD;
    end
  end

  // change and edge detection
  always_comb begin
    chgHit = |((pinSync ^ refQ) & wakeEnQ);
    extHit = edgeRiseQ ? (pinSync[0] & ~pin0PrevQ) : (~pinSync[0] & pin0PrevQ);
    flagD  = stb.wrFlag ? {wdata[BIT_CHG], wdata[BIT_EXT]} : flagQ;
    if (chgHit) flagD[1] = 1'b1;
    if (extHit) flagD[0] = 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (rdSel)
      REG_DATA:    rdata = pinSync;
      REG_DIR:     rdata = dirQ;
      REG_WAKEEN:  rdata = wakeEnQ;
      REG_ODRAIN:  rdata = odQ;
      REG_PULL:    rdata = pullQ;
      REG_IRQEN: begin
        rdata[BIT_GLOBAL] = ieQ[2];
        rdata[BIT_CHG]    = ieQ[1];
        rdata[BIT_EXT]    = ieQ[0];
      end
      REG_IRQFLAG: begin
        rdata[BIT_CHG] = flagQ[1];
        rdata[BIT_EXT] = flagQ[0];
      end
      REG_CTRL:    rdata[0] = edgeRiseQ;
      default:     rdata = '0;
    endcase
  end

  assign pinOut = dataQ;
  assign pinOe  = ~dirQ;
  assign odEn   = odQ;
  assign pullEn = pullQ;
  assign irq    = ieQ[2] & |(flagQ & ieQ[1:0]);
  assign wake   = flagQ[1] & (|wakeEnQ);
endmodule

// File: rtl/pinwake_top.sv
module pinwake_top
  import pinwake_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] odEn,
  output logic [WIDTH-1:0] pullEn,
  output logic             irq,
  output logic             wake
);
  strobes_t         stb;
  regSel_e          rdSel;
  logic [1:0]       flagQ;
  logic [2:0]       ieQ;
  logic [WIDTH-1:0] wakeEnQ;

  pinwake_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  pinwake_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdSel   (rdSel),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .rdata   (busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .odEn    (odEn),
    .pullEn  (pullEn),
    .irq     (irq),
    .wake    (wake),
    .flagQ   (flagQ),
    .ieQ     (ieQ),
    .wakeEnQ (wakeEnQ)
  );
endmodule

// File: rtl/pinwake_checker.sv
module pinwake_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       busAddr,
  input logic             busWr,
  input logic [WIDTH-1:0] busWdata,
  input logic [WIDTH-1:0] pinOe,
  input logic             irq,
  input logic             wake,
  input logic [1:0]       flagQ,
  input logic [2:0]       ieQ,
  input logic [WIDTH-1:0] wakeEnQ
);
  logic flagWrite;
  assign flagWrite = busWr && (busAddr == 3'd6);

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd1) |=> (pinOe == ~$past(busWdata)));

  assert_disabled_pins_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wakeEnQ == '0 && !flagQ[1] && !flagWrite) |=> !flagQ[1]);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[1] && !flagWrite) |=> flagQ[1]);

  assert_irq_needs_global_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ieQ[2]);

  assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> (flagQ[1] && wakeEnQ != '0));
endmodule

bind pinwake_top pinwake_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .pinOe    (pinOe),
  .irq      (irq),
  .wake     (wake),
  .flagQ    (flagQ),
  .ieQ      (ieQ),
  .wakeEnQ  (wakeEnQ)
);

// File: tb/pinwake_top_tb.sv
`timescale 1ns/1ps
module pinwake_top_tb;
  localparam int W = 8;
  localparam int SETTLE = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   busAddr = '0;
  logic         busWr = 1'b0;
  logic         busRd = 1'b0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut, pinOe, odEn, pullEn;
  logic         irq, wake;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pinwake_top #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .odEn(odEn), .pullEn(pullEn), .irq(irq), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic setPins(input logic [W-1:0] v);
    @(negedge clk);
    pinIn = v;
    waitCyc(SETTLE);
  endtask

  logic [W-1:0] rd;

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1: reset state
    busRead(3'd1, rd); chk("R1 dir", rd, 8'hFF);
    busRead(3'd6, rd); chk("R1 flag", rd, 8'h00);
    chk("R1 pinOe", pinOe, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake", wake, 1'b0);

    // R2: pin levels read back for both directions; latch and enable drive
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] pat;
      pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hA5 : (p == 2) ? 8'h3C : 8'hFF;
      busWrite(3'd1, (p % 2 == 0) ? 8'hFF : 8'h00);
      setPins(pat);
      busRead(3'd0, rd); chk("R2 port read", rd, pat);
    end
    busWrite(3'd0, 8'h96); chk("R2 pinOut", pinOut, 8'h96);
    busWrite(3'd1, 8'h0F); chk("R2 pinOe", pinOe, 8'hF0);
    busWrite(3'd1, 8'hFF);
    setPins(8'h00);
    busRead(3'd0, rd);
    busWrite(3'd6, 8'h00);

    // R9: pad control registers
    busWrite(3'd3, 8'hC3); busWrite(3'd4, 8'h5A);
    busRead(3'd3, rd); chk("R9 od readback", rd, 8'hC3);
    busRead(3'd4, rd); chk("R9 pull readback", rd, 8'h5A);
    chk("R9 odEn", odEn, 8'hC3);
    chk("R9 pullEn", pullEn, 8'h5A);

    // R3 / R4 / R8: sweep every pin, enabled and ignored
    for (int n = 0; n < W; n++) begin
      for (int en = 0; en < 2; en++) begin
        logic [W-1:0] one;
        one = 8'h01 << n;
        busWrite(3'd2, (en == 1) ? one : ~one);
        busRead(3'd0, rd);
        busWrite(3'd6, 8'h00);
        setPins(one);
        busRead(3'd6, rd);
        if (en == 1) begin
          chk("R3 change flag set", rd[1], 1'b1);
          chk("R8 wake on change", wake, 1'b1);
        end else begin
          chk("R4 ignored pin", rd[1], 1'b0);
          chk("R4 no wake", wake, 1'b0);
        end
        setPins(8'h00);
        busRead(3'd0, rd);
        busWrite(3'd6, 8'h00);
      end
    end

    // R5: sticky flag, re-set while mismatch stays
    busWrite(3'd2, 8'hFF);
    busRead(3'd0, rd);
    busWrite(3'd6, 8'h00);
    setPins(8'h10);
    busWrite(3'd6, 8'h00);
    waitCyc(2);
    busRead(3'd6, rd); chk("R5 reset while mismatch", rd[1], 1'b1);
    busRead(3'd0, rd);
    busWrite(3'd6, 8'h00);
    waitCyc(2);
    busRead(3'd6, rd); chk("R5 cleared after ref update", rd[1], 1'b0);
    waitCyc(3);
    busRead(3'd6, rd); chk("R5 stays clear", rd[1], 1'b0);
    setPins(8'h00);
    busWrite(3'd2, 8'h00);
    busWrite(3'd6, 8'h00);

    // R6: pin 0 edge select
    for (int es = 0; es < 2; es++) begin
      busWrite(3'd7, es[7:0]);
      busWrite(3'd6, 8'h00);
      setPins(8'h01);
      busRead(3'd6, rd); chk("R6 rising edge", rd[0], (es == 1) ? 1'b1 : 1'b0);
      busWrite(3'd6, 8'h00);
      setPins(8'h00);
      busRead(3'd6, rd); chk("R6 falling edge", rd[0], (es == 0) ? 1'b1 : 1'b0);
      busWrite(3'd6, 8'h00);
    end

    // R7: exhaustive enable x flag sweep
    for (int ie = 0; ie < 8; ie++) begin
      for (int f = 0; f < 4; f++) begin
        logic expIrq;
        busWrite(3'd5, {ie[2], 5'b0, ie[1], ie[0]});
        busWrite(3'd6, f[7:0]);
        expIrq = ie[2] & ((f[1] & ie[1]) | (f[0] & ie[0]));
        chk("R7 irq", irq, expIrq);
      end
    end

    // R8: wake independent of interrupt enables
    busWrite(3'd5, 8'h00);
    busWrite(3'd2, 8'h01);
    busWrite(3'd6, 8'h02);
    chk("R8 wake with masks clear", wake, 1'b1);
    chk("R8 irq stays low", irq, 1'b0);
    busWrite(3'd2, 8'h00);
    chk("R8 no wake without enabled pin", wake, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule